// File: doc/BRIEF.md
# Bus Register Swap Controller

This block exchanges the contents of two data registers that share one bus, parking one value in a third, temporary register along the way. A start pulse that lasts one clock launches a fixed sequence of three bus transfers. Each transfer asserts exactly one bus-drive enable and one load enable together. The last transfer also raises a completion flag, and the controller then goes back to idle.

The datapath holds three registers of `DATA_W` bits: the first operand, the second operand and the temporary. A shared bus is modelled as an AND-OR multiplexer rather than tri-state lines. A register captures the bus value on the clock edge that closes the cycle in which its load enable is high. A per-register preset path lets surrounding logic place values in the registers while the controller is idle.

The sequencer keeps one flip-flop per state. Every strobe is therefore a direct flip-flop output, with no decode logic between the state and the pins.

Top module: `reg_swap_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, the unit returns to idle. After that edge all drive and load enables and `done` are 0, and all three registers hold 0.
- R2: In idle with `start` low, the unit stays idle and every enable and `done` stay 0.
- R3: A rising edge that samples `start` high in idle begins step one. In the following cycle, `drv_en` = 3'b010 (second operand drives) and `ld_en` = 3'b100 (temporary loads). Enable bit 0 is the first operand, bit 1 the second operand and bit 2 the temporary.
- R4: The cycle after step one is step two, with `drv_en` = 3'b001 and `ld_en` = 3'b010 (first operand copied into the second).
- R5: The cycle after step two is step three, with `drv_en` = 3'b100, `ld_en` = 3'b001 and `done` = 1 (temporary copied into the first operand). `done` is 1 in no other cycle.
- R6: After step three the unit always returns to idle, with all enables and `done` at 0.
- R7: No more than one bit of `drv_en` is set in any cycle.
- R8: `bus_q` equals the register whose drive enable is set, and equals 0 when no drive enable is set.
- R9: A register whose load enable is low, and which is not being preset, keeps its value.
- R10: A `start` pulse that arrives while a swap is in progress is ignored. The running sequence carries on unchanged, and no second swap follows it.
- R11: Each bit of `ext_ld` (same bit order as R3) loads `ext_data` into that register on the next edge, but only while the unit is idle. Outside idle the preset is ignored.
- R12: When a swap completes, the first and second operands have exchanged their values, and the temporary holds the original second operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request to begin a swap |
| ext_ld | input | 3 | Per-register preset strobes, honoured only in idle |
| ext_data | input | DATA_W | Preset value |
| reg1_q | output | DATA_W | First operand register |
| reg2_q | output | DATA_W | Second operand register |
| reg3_q | output | DATA_W | Temporary register |
| bus_q | output | DATA_W | Shared bus value |
| drv_en | output | 3 | Bus drive enables, one per register |
| ld_en | output | 3 | Load enables, one per register |
| done | output | 1 | High during the final transfer cycle |

## Verification
The assertions take for granted two things about the inputs. `start` is a clean synchronous level, and reset is held high from time zero through at least one rising edge. The step-order properties then follow the one-hot state from its first defined value. The bench changes every input only on falling edges, holds reset for several cycles, and raises `start` for exactly one cycle each time. This includes the deliberate pulse it sends in the middle of a swap. Preset strobes are applied both in idle and inside a running swap, so that the gating rule of R11 is tested in both directions.

// File: rtl/swap_pkg.sv
package swap_pkg;
  localparam int NREG   = 3;
  localparam int NSTATE = 4;

  // register slots on the shared bus
  localparam int RA = 0;   // first operand
  localparam int RB = 1;   // second operand
  localparam int RT = 2;   // temporary

  // one-hot state bit positions
  localparam int S_IDLE = 0;
  localparam int S_B2T  = 1;   // second -> temporary
  localparam int S_A2B  = 2;   // first -> second
  localparam int S_T2A  = 3;   // temporary -> first, completion

  typedef logic [NSTATE-1:0] onehot_t;
  typedef logic [NREG-1:0]   strobe_t;

  localparam onehot_t IDLE_OH = onehot_t'(1 << S_IDLE);
endpackage

// File: rtl/swap_seq_ctrl.sv
module swap_seq_ctrl
  import swap_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    start,
  output strobe_t drv,
  output strobe_t ld,
  output logic    done,
  output logic    idle
);
  onehot_t st, st_nx;
  logic    st_bad;

  assign st_bad = (st == '0) || ((st & (st - onehot_t'(1))) != '0);

  always_comb begin
    st_nx         = '0;
    st_nx[S_IDLE] = (st[S_IDLE] & ~start) | st[S_T2A];
    st_nx[S_B2T]  = st[S_IDLE] & start;
    st_nx[S_A2B]  = st[S_B2T];
    st_nx[S_T2A]  = st[S_A2B];
    if (st_bad) st_nx = IDLE_OH;
  end

  always_ff @(posedge clk) begin
    if (rst) st <= IDLE_OH;
    else     st <= st_nx;
  end

  // every strobe is a state flop output
  assign drv[RA] = st[S_A2B];
  assign drv[RB] = st[S_B2T];
  assign drv[RT] = st[S_T2A];
  assign ld[RA]  = st[S_T2A];
  assign ld[RB]  = st[S_A2B];
  assign ld[RT]  = st[S_B2T];
  assign done    = st[S_T2A];
  assign idle    = st[S_IDLE];

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (idle && !start) |=> (idle && drv == '0 && ld == '0 && !done));
  p_step1_r3: assert property (@(posedge clk) disable iff (rst)
    (idle && start) |=> (drv == 3'b010 && ld == 3'b100 && !done));
  p_step2_r4: assert property (@(posedge clk) disable iff (rst)
    (drv == 3'b010) |=> (drv == 3'b001 && ld == 3'b010 && !done));
  p_step3_r5: assert property (@(posedge clk) disable iff (rst)
    (drv == 3'b001) |=> (drv == 3'b100 && ld == 3'b001 && done));
  p_return_r6: assert property (@(posedge clk) disable iff (rst)
    done |=> (idle && drv == '0 && ld == '0));
  p_busy_start_r10: assert property (@(posedge clk) disable iff (rst)
    (!idle && start && !done) |=> !idle);
  p_one_driver_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(drv));
endmodule

// File: rtl/swap_regs.sv
module swap_regs
  import swap_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                           clk,
  input  logic                           rst,
  input  strobe_t                        ld,
  input  strobe_t                        ext_ld,
  input  logic                           ext_ok,
  input  logic [DATA_W-1:0]              bus,
  input  logic [DATA_W-1:0]              ext_data,
  output logic [NREG-1:0][DATA_W-1:0]    q
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic pre;
    assign pre = ext_ld[g] & ext_ok;

    always_ff @(posedge clk) begin
      if (rst)        q[g] <= '0;
      else if (ld[g]) q[g] <= bus;
      else if (pre)   q[g] <= ext_data;
    end

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
      (!ld[g] && !pre) |=> $stable(q[g]));
    p_capture_r12: assert property (@(posedge clk) disable iff (rst)
      ld[g] |=> (q[g] == $past(bus)));
    p_preset_r11: assert property (@(posedge clk) disable iff (rst)
      (pre && !ld[g]) |=> (q[g] == $past(ext_data)));
  end
endmodule

// File: rtl/swap_bus_mux.sv
module swap_bus_mux
  import swap_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  strobe_t                        drv,
  input  logic [NREG-1:0][DATA_W-1:0]    src,
  output logic [DATA_W-1:0]              bus
);
  // AND-OR stands in for shared tri-state lines; idle bus reads zero
  always_comb begin
    bus = '0;
    for (int i = 0; i < NREG; i++) begin
      bus = bus | (src[i] & {DATA_W{drv[i]}});
    end
  end
endmodule

// File: rtl/reg_swap_unit.sv
module reg_swap_unit
  import swap_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [2:0]        ext_ld,
  input  logic [DATA_W-1:0] ext_data,
  output logic [DATA_W-1:0] reg1_q,
  output logic [DATA_W-1:0] reg2_q,
  output logic [DATA_W-1:0] reg3_q,
  output logic [DATA_W-1:0] bus_q,
  output logic [2:0]        drv_en,
  output logic [2:0]        ld_en,
  output logic              done
);
  strobe_t                     drv, ld;
  logic                        idle;
  logic [NREG-1:0][DATA_W-1:0] q;
  logic [DATA_W-1:0]           bus;

  swap_seq_ctrl u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .drv   (drv),
    .ld    (ld),
    .done  (done),
    .idle  (idle)
  );

  swap_regs #(.DATA_W(DATA_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .ld       (ld),
    .ext_ld   (ext_ld),
    .ext_ok   (idle),
    .bus      (bus),
    .ext_data (ext_data),
    .q        (q)
  );

  swap_bus_mux #(.DATA_W(DATA_W)) u_bus (
    .drv (drv),
    .src (q),
    .bus (bus)
  );

  assign reg1_q = q[RA];
  assign reg2_q = q[RB];
  assign reg3_q = q[RT];
  assign bus_q  = bus;
  assign drv_en = drv;
  assign ld_en  = ld;

  p_bus_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (drv == '0) |-> (bus == '0));
  p_bus_src_r8: assert property (@(posedge clk) disable iff (rst)
    drv[RB] |-> (bus == q[RB]));
  p_busy_preset_r11: assert property (@(posedge clk) disable iff (rst)
    (!idle && !ld[RA]) |=> $stable(q[RA]));
endmodule

// File: tb/tb_reg_swap_unit.sv
`timescale 1ns/1ps
module tb_reg_swap_unit;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [2:0]   ext_ld = '0;
  logic [W-1:0] ext_data = '0;
  logic [W-1:0] reg1_q, reg2_q, reg3_q, bus_q;
  logic [2:0]   drv_en, ld_en;
  logic         done;

  int tests = 0;
  int fails = 0;
  logic [W-1:0] m1, m2, m3;   // bench model of register contents

  always #2.5 clk = ~clk;

  reg_swap_unit #(.DATA_W(W)) dut (
    .clk(clk), .rst(rst), .start(start), .ext_ld(ext_ld), .ext_data(ext_data),
    .reg1_q(reg1_q), .reg2_q(reg2_q), .reg3_q(reg3_q), .bus_q(bus_q),
    .drv_en(drv_en), .ld_en(ld_en), .done(done)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_regs(input string req);
    check(req, "reg1", 32'(reg1_q), 32'(m1));
    check(req, "reg2", 32'(reg2_q), 32'(m2));
    check(req, "reg3", 32'(reg3_q), 32'(m3));
  endtask

  task automatic check_quiet(input string req);
    check(req, "drv_en", 32'(drv_en), 32'd0);
    check(req, "ld_en", 32'(ld_en), 32'd0);
    check(req, "done", 32'(done), 32'd0);
    check(req, "bus idle zero", 32'(bus_q), 32'd0);
  endtask

  task automatic test_reset();
    check_quiet("R1");
    m1 = '0; m2 = '0; m3 = '0;
    check_regs("R1");
  endtask

  task automatic test_idle_hold();
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check_quiet("R2");
      check_regs("R9");
    end
  endtask

  task automatic preset(input logic [2:0] mask, input logic [W-1:0] v);
    ext_ld = mask; ext_data = v;
    @(negedge clk);
    ext_ld = '0;
    if (mask[0]) m1 = v;
    if (mask[1]) m2 = v;
    if (mask[2]) m3 = v;
    check_regs("R11");
  endtask

  // called at a falling edge in idle; start is raised at once
  task automatic test_swap();
    logic [W-1:0] a, b;
    a = m1; b = m2;
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    check("R3", "drv step1", 32'(drv_en), 32'b010);
    check("R3", "ld step1", 32'(ld_en), 32'b100);
    check("R8", "bus step1", 32'(bus_q), 32'(b));
    @(negedge clk);
    check("R4", "reg3 after step1", 32'(reg3_q), 32'(b));
    check("R4", "drv step2", 32'(drv_en), 32'b001);
    check("R4", "ld step2", 32'(ld_en), 32'b010);
    check("R8", "bus step2", 32'(bus_q), 32'(a));
    @(negedge clk);
    check("R5", "reg2 after step2", 32'(reg2_q), 32'(a));
    check("R5", "drv step3", 32'(drv_en), 32'b100);
    check("R5", "ld step3", 32'(ld_en), 32'b001);
    check("R5", "done step3", 32'(done), 32'd1);
    @(negedge clk);
    m1 = b; m2 = a; m3 = b;
    check_quiet("R6");
    check_regs("R12");
  endtask

  task automatic test_start_while_busy();
    logic [W-1:0] a, b;
    a = m1; b = m2;
    start = 1'b1;
    @(negedge clk); start = 1'b0;     // step one
    @(negedge clk); start = 1'b1;     // step two, second pulse
    @(negedge clk); start = 1'b0;     // step three
    check("R10", "drv step3 unchanged", 32'(drv_en), 32'b100);
    check("R10", "done step3", 32'(done), 32'd1);
    @(negedge clk);
    m1 = b; m2 = a; m3 = b;
    check_quiet("R10");
    @(negedge clk);
    check_quiet("R10");
    check_regs("R10");
  endtask

  task automatic test_preset_while_busy();
    logic [W-1:0] a, b;
    a = m1; b = m2;
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    ext_ld = 3'b111; ext_data = 8'hFF; // steps one and two
    @(negedge clk);
    @(negedge clk); ext_ld = '0;
    check("R11", "reg1 untouched mid swap", 32'(reg1_q), 32'(a));
    @(negedge clk);
    m1 = b; m2 = a; m3 = b;
    check_regs("R11");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst = 1'b0;
    test_idle_hold();
    preset(3'b001, 8'hA5);
    preset(3'b010, 8'h3C);
    test_swap();
    test_swap();                      // back-to-back from the idle cycle
    preset(3'b111, 8'h00);
    preset(3'b001, 8'h81);
    preset(3'b010, 8'h7E);
    test_swap();
    test_idle_hold();
    test_start_while_busy();
    preset(3'b011, 8'h55);
    preset(3'b010, 8'hC3);
    test_preset_while_busy();
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    test_reset();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule